// File: doc/BRIEF.md
# Strobe-Sequenced Accumulating Adder

This block sums a series of binary words into an accumulator. It holds two registers around a ripple-carry adder. An operand register takes a word from the data input when the load strobe is high. The accumulator takes the adder output, accumulator plus operand, when the transfer strobe is high. A clear strobe zeroes the accumulator. A controller that clears once and then issues a load and a transfer for each word is left with the running total of those words.

Every strobe is sampled on the rising clock edge, and the registers change on that edge. The carry out of the top adder stage is stored with the accumulator on each transfer and is shown as a flag. The word width is a parameter with a default of 4.

Top module: `strobe_accum`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator, the operand register and the carry flag all become 0.
- R2: `clr_stb` high at a rising edge sets `acc_q` to 0 and `carry_q` to 0 after that edge. The operand register keeps its value.
- R3: `load_stb` high at a rising edge copies `din` into the operand register.
- R4: `xfer_stb` high (with `clr_stb` low) at a rising edge sets `acc_q` to (acc + operand) mod 2^W. It sets `carry_q` to bit W of the full W+1-bit sum.
- R5: When `clr_stb` and `xfer_stb` are both high at the same edge, the clear wins: `acc_q` and `carry_q` become 0.
- R6: When `load_stb` and `xfer_stb` are both high at the same edge, the sum uses the operand value from before that edge. The new `din` is still loaded.
- R7: With no strobe high, `acc_q`, `carry_q` and the operand register all keep their values.
- R8: With W=4, the sequence clear, load 1001, transfer, load 0101, transfer leaves `acc_q` = 1110 and `carry_q` = 0.
- R9: The first transfer after a clear makes `acc_q` equal to the operand loaded last.
- R10: A transfer whose sum wraps (for example 1111 + 0001) gives `acc_q` = 0000 and `carry_q` = 1. The next transfer that does not wrap sets `carry_q` back to 0.
- R11: A load without a transfer or a clear leaves `acc_q` and `carry_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_stb | input | 1 | Zero the accumulator and the carry flag |
| load_stb | input | 1 | Capture `din` into the operand register |
| xfer_stb | input | 1 | Capture accumulator + operand into the accumulator |
| din | input | W | Operand word |
| acc_q | output | W | Accumulator contents |
| carry_q | output | 1 | Carry out stored by the last transfer |

## Verification
Every result in this block appears exactly one rising edge after the strobe that causes it. The accumulator and the carry flag are registered straight from the adder, and the operand register loads straight from `din`. The bench applies each strobe pattern at a falling edge and reads `acc_q` and `carry_q` at the next falling edge, half a cycle after the edge that captured the pattern. The operand register has no output port, so its value is checked one cycle later: a clear is followed by a transfer, which brings the operand out onto `acc_q` (R9).

// File: rtl/strobe_accum_pkg.sv
// Package: types shared by the accumulating adder.
// Assumes: strobes are already synchronous to the adder clock.
package strobe_accum_pkg;

    // Action taken by the accumulator on the coming edge.
    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_CLEAR = 2'd1,
        ACC_SUM   = 2'd2
    } acc_act_e;

    // Raw strobe bundle as seen at the block edge.
    typedef struct packed {
        logic clr;
        logic load;
        logic xfer;
    } strobe_t;

endpackage

// File: rtl/fa_cell.sv
// Module: one-bit full adder.
// Assumes: nothing; pure combinational cell used in the ripple chain.
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum bit and carry-out of one bit position.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (ci & (a ^ b));
    end
endmodule

// File: rtl/ripple_sum.sv
// Module: W-bit ripple-carry adder, carry-in tied to zero.
// Assumes: W >= 1; the carry path grows linearly with W.
module ripple_sum #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NC = W + 1;

    logic [NC-1:0] c;

    // Carry into bit 0 is always zero.
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_cell u_fa (
            .a  (x[i]),
            .b  (y[i]),
            .ci (c[i]),
            .s  (sum[i]),
            .co (c[i+1])
        );
    end

    // Carry out of the top stage.
    assign cout = c[NC-1];
endmodule

// File: rtl/strobe_decode.sv
// Module: turns the three strobes into the accumulator action and the operand enable.
// Assumes: clear outranks transfer; load is independent of both.
module strobe_decode
    import strobe_accum_pkg::*;
(
    input  strobe_t  stb,
    output acc_act_e act,
    output logic     opd_en
);
    // Priority: clear, then transfer, else hold.
    always_comb begin
        if (stb.clr)       act = ACC_CLEAR;
        else if (stb.xfer) act = ACC_SUM;
        else               act = ACC_HOLD;
        opd_en = stb.load;
    end
endmodule

// File: rtl/word_reg.sv
// Module: W-bit register with load enable and synchronous active-low reset.
// Assumes: d is stable around the rising edge.
module word_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d on enable; zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/accum_reg.sv
// Module: accumulator and carry flag, updated together by the decoded action.
// Assumes: sum_in and cout_in come from the adder fed by this register.
module accum_reg
    import strobe_accum_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_act_e     act,
    input  logic [W-1:0] sum_in,
    input  logic         cout_in,
    output logic [W-1:0] acc_q,
    output logic         carry_q
);
    // Clear, load the sum with its carry, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            unique case (act)
                ACC_CLEAR: begin
                    acc_q   <= '0;
                    carry_q <= 1'b0;
                end
                ACC_SUM: begin
                    acc_q   <= sum_in;
                    carry_q <= cout_in;
                end
                default: begin
                    acc_q   <= acc_q;
                    carry_q <= carry_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/strobe_accum.sv
// Module: top of the accumulating adder (operand register, ripple adder, accumulator).
// Assumes: strobes and din are synchronous to clk; at most the documented
//          strobe combinations matter (clear beats transfer, load is free).
module strobe_accum
    import strobe_accum_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_stb,
    input  logic         load_stb,
    input  logic         xfer_stb,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc_q,
    output logic         carry_q
);
    strobe_t      stb;
    acc_act_e     act;
    logic         opd_en;
    logic [W-1:0] opd_q;
    logic [W-1:0] sum_w;
    logic         cout_w;

    // Bundle the strobes for the decoder.
    always_comb begin
        stb.clr  = clr_stb;
        stb.load = load_stb;
        stb.xfer = xfer_stb;
    end

    strobe_decode u_dec (
        .stb    (stb),
        .act    (act),
        .opd_en (opd_en)
    );

    word_reg #(.W(W)) u_opd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (opd_en),
        .d     (din),
        .q     (opd_q)
    );

    ripple_sum #(.W(W)) u_add (
        .x    (acc_q),
        .y    (opd_q),
        .sum  (sum_w),
        .cout (cout_w)
    );

    accum_reg #(.W(W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .sum_in  (sum_w),
        .cout_in (cout_w),
        .acc_q   (acc_q),
        .carry_q (carry_q)
    );
endmodule

// File: rtl/strobe_accum_chk.sv
// Module: property checker for strobe_accum, bound to every instance.
// Assumes: opd_q is the operand register inside the top.
module strobe_accum_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_stb,
    input logic         load_stb,
    input logic         xfer_stb,
    input logic [W-1:0] din,
    input logic [W-1:0] acc_q,
    input logic         carry_q,
    input logic [W-1:0] opd_q
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && opd_q == '0 && !carry_q));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (acc_q == '0 && !carry_q));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (opd_q == $past(din)));

    // R4
    xfer_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !clr_stb) |=>
            ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(opd_q)})));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_stb && !load_stb && !xfer_stb) |=>
            ($stable(acc_q) && $stable(carry_q) && $stable(opd_q)));

    // R11
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !clr_stb && !xfer_stb) |=> ($stable(acc_q) && $stable(carry_q)));

    // R2
    clear_keeps_opd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !load_stb) |=> $stable(opd_q));
endmodule

bind strobe_accum strobe_accum_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_stb  (clr_stb),
    .load_stb (load_stb),
    .xfer_stb (xfer_stb),
    .din      (din),
    .acc_q    (acc_q),
    .carry_q  (carry_q),
    .opd_q    (opd_q)
);

// File: tb/strobe_accum_test.sv
// Bench: directed scenarios for strobe_accum, one task per scenario.
// Inputs change at falling edges; outputs are read one falling edge later.
module strobe_accum_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_stb = 1'b0;
    logic         load_stb = 1'b0;
    logic         xfer_stb = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] acc_q;
    logic         carry_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    strobe_accum #(.W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_stb  (clr_stb),
        .load_stb (load_stb),
        .xfer_stb (xfer_stb),
        .din      (din),
        .acc_q    (acc_q),
        .carry_q  (carry_q)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Apply one strobe pattern for one cycle, then settle at the next falling edge.
    task automatic step(input logic c, input logic l, input logic x, input logic [W-1:0] d);
        clr_stb  = c;
        load_stb = l;
        xfer_stb = x;
        din      = d;
        @(negedge clk);
        clr_stb  = 1'b0;
        load_stb = 1'b0;
        xfer_stb = 1'b0;
    endtask

    // Compare both outputs with the expected values.
    task automatic expect_out(input string req, input logic [W-1:0] ea, input logic ec);
        n_chk++;
        if (acc_q !== ea || carry_q !== ec) begin
            n_bad++;
            $display("FAIL %s: acc=%b carry=%b, expected acc=%b carry=%b",
                     req, acc_q, carry_q, ea, ec);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_out("R1", 4'b0000, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 1, 4'b0000);          // operand must also be zero after reset
        expect_out("R1", 4'b0000, 1'b0);
    endtask

    // R8 and R9: the worked sequence.
    task automatic t_sequence();
        step(1, 0, 0, 4'b0000);
        expect_out("R2", 4'b0000, 1'b0);
        step(0, 1, 0, 4'b1001);
        expect_out("R11", 4'b0000, 1'b0);
        step(0, 0, 1, 4'b0000);
        expect_out("R9", 4'b1001, 1'b0);
        step(0, 1, 0, 4'b0101);
        step(0, 0, 1, 4'b0000);
        expect_out("R8", 4'b1110, 1'b0);
    endtask

    // R7: idle cycles hold everything, operand included.
    task automatic t_hold();
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 4'b1111);
            expect_out("R7", 4'b1110, 1'b0);
        end
        step(1, 0, 0, 4'b0000);
        step(0, 0, 1, 4'b0000);
        expect_out("R7", 4'b0101, 1'b0);   // operand kept 0101 through idle and clear (R2)
    endtask

    // R10: wrap sets carry; a later non-wrapping transfer clears it.
    task automatic t_carry();
        step(1, 1, 0, 4'b1111);
        step(0, 0, 1, 4'b0000);
        expect_out("R10", 4'b1111, 1'b0);
        step(0, 1, 0, 4'b0001);
        step(0, 0, 1, 4'b0000);
        expect_out("R10", 4'b0000, 1'b1);
        step(0, 0, 0, 4'b0000);
        expect_out("R7", 4'b0000, 1'b1);
        step(0, 0, 1, 4'b0000);
        expect_out("R10", 4'b0001, 1'b0);
        step(0, 1, 0, 4'b1000);
        step(0, 0, 1, 4'b0000);
        step(0, 0, 1, 4'b0000);
        expect_out("R4", 4'b0001, 1'b1);   // 1001 + 1000 = 1_0001
    endtask

    // R5: clear beats transfer; R2 clears carry.
    task automatic t_priority();
        step(1, 0, 1, 4'b0000);
        expect_out("R5", 4'b0000, 1'b0);
    endtask

    // R6: load and transfer together sum with the old operand.
    task automatic t_overlap();
        step(1, 1, 0, 4'b0011);
        step(0, 1, 1, 4'b0110);
        expect_out("R6", 4'b0011, 1'b0);
        step(0, 0, 1, 4'b0000);
        expect_out("R6", 4'b1001, 1'b0);   // 0011 + new operand 0110
        step(0, 1, 1, 4'b0010);
        expect_out("R4", 4'b1111, 1'b0);
        step(0, 0, 1, 4'b0000);
        expect_out("R4", 4'b0001, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: acc=%b carry=%b, expected run to finish", acc_q, carry_q);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sequence();
        t_hold();
        t_carry();
        t_priority();
        t_overlap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule